// File: doc/BRIEF.md
# Open-Drain Serial Byte Transmitter with Collision Check

This block sends one byte at a time over a single serial line shared by several devices. An external resistor pulls the line high, and each device can only pull it low. The block never drives the line high. It has one enable output: when that output is set, a low driver outside the block pulls the line down; when it is clear, the line is left to the pull-up. Each frame has a low start bit, eight data bits sent least significant bit first, and a released stop bit. Each bit lasts `BIT_CYCLES` clock cycles.

Because the line is a wired-AND, another device can hold it low while this block is trying to send a 1. The block watches for this. For every 1 bit it reads the line back through a two-flop synchronizer near the middle of the bit. If the line reads low, it abandons the frame and reports a collision. A frame that ends normally reports success after its stop bit. Retrying after a collision, parity and any buffering are left to the logic around the block.

Top module: `odl_byte_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it, `drive_low_o`, `busy_o`, `done_o`, `ok_o` and `collide_o` are all 0. The line is released.
- R2: `start_i` is accepted in a cycle where `busy_o` is 0, and `byte_i` is captured at that edge. From the next cycle on, `busy_o` is 1 and `drive_low_o` is 1 for exactly `BIT_CYCLES` cycles (the start bit).
- R3: Data bit i (i = 0..7, bit 0 first) occupies cycles `(1+i)*BIT_CYCLES` to `(2+i)*BIT_CYCLES-1`, counted from the first start-bit cycle. `drive_low_o` is 1 for the whole bit when `byte_i[i]` is 0, and 0 for the whole bit when it is 1.
- R4: The stop bit keeps `drive_low_o` at 0 for `BIT_CYCLES` cycles. In the next cycle, `done_o` and `ok_o` pulse high for one cycle and `busy_o` returns to 0. A clean frame therefore keeps `busy_o` high for `10*BIT_CYCLES` cycles.
- R5: During a 1 data bit, let HALF be `BIT_CYCLES/2` rounded down. The two-flop synchronizer output is tested in bit cycle HALF-1, and in that cycle it reflects the line level at bit cycle HALF-3. If that level is low, then in the following cycle `done_o` and `collide_o` pulse, `ok_o` stays 0, `busy_o` falls and the line stays released. For a collision in bit k, `busy_o` is therefore high for `(1+k)*BIT_CYCLES + HALF` cycles.
- R6: The line level has no effect at any other time: during the start bit, during 0 data bits, during the stop bit, or outside the test cycle of a 1 bit. A frame in which the line is held low only at those times still ends with `ok_o` after `10*BIT_CYCLES` cycles.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The running frame's drive pattern and its result are unchanged.
- R8: `done_o` is high exactly when one of `ok_o` or `collide_o` is high, and never when both are high.
- R9: `drive_low_o` is 0 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send `byte_i`; taken only when idle |
| byte_i | input | 8 | Byte to send, captured with an accepted start |
| line_i | input | 1 | Raw level of the shared line (asynchronous) |
| drive_low_o | output | 1 | 1 = enable the low driver; 0 = release the line |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse when a frame ends |
| ok_o | output | 1 | One-cycle pulse with `done_o`: frame sent cleanly |
| collide_o | output | 1 | One-cycle pulse with `done_o`: line read low during a 1 bit |

## Verification
The main function is tested with several bytes, 0xA5, 0x00, 0xFF, 0x01 and 0x80, sent with no other device on the line. These separate least-significant-bit-first order from reversed order, and all-low frames from all-released frames. An emulated second device then pulls the line low over chosen windows. A whole 1 bit must be reported as a collision, with the frame ending at the expected cycle. Windows that end just before the test cycle, or begin just after it, must not be reported, and this pins the sampling point to a single cycle. Windows over 0 bits and over the stop bit must also go unreported. Start pulses during a frame must change nothing, and the drive pattern must still match the behavioural model cycle by cycle.

// File: rtl/odl_tx_pkg.sv
package odl_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/odl_line_sync.sv
module odl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_sync_o
);

    generate
        if (STAGES <= 1) begin : g_single
            logic ff_d, ff_q;

            always_comb begin
                ff_d = line_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= 1'b1;
                else        ff_q <= ff_d;
            end

            assign line_sync_o = ff_q;
        end else begin : g_chain
            logic [STAGES-1:0] ff_d, ff_q;

            always_comb begin
                ff_d = {ff_q[STAGES-2:0], line_i};
            end

            // Reset to the released (high) line level.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '1;
                else        ff_q <= ff_d;
            end

            assign line_sync_o = ff_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/odl_bit_timer.sv
module odl_bit_timer #(
    parameter int BIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic at_half_o,
    output logic at_end_o
);

    localparam int CW   = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam int HALF = BIT_CYCLES / 2;
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
    localparam logic [CW-1:0] END_M1  = CW'(BIT_CYCLES - 1);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (restart_i) begin
            count_d = '0;
        end else if (run_i) begin
            if (count_q == END_M1) count_d = '0;
            else                   count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign at_half_o = run_i && (count_q == HALF_M1);
    assign at_end_o  = run_i && (count_q == END_M1);

endmodule

// File: rtl/odl_tx_fsm.sv
module odl_tx_fsm
    import odl_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_BITS-1:0] byte_i,
    input  logic                 line_sync_i,
    input  logic                 at_half_i,
    input  logic                 at_end_i,
    output logic                 run_o,
    output logic                 restart_o,
    output logic                 drive_low_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 ok_o,
    output logic                 collide_o
);

    localparam int IW = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

    typedef struct packed {
        tx_state_e            state;
        logic [DATA_BITS-1:0] shift;
        logic [IW-1:0]        idx;
        logic                 drive;
        logic                 done;
        logic                 ok;
        logic                 coll;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;
    logic      restart;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ok   = 1'b0;
        r_d.coll = 1'b0;
        restart  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_START;
                    r_d.shift = byte_i;
                    r_d.idx   = '0;
                    restart   = 1'b1;
                end
            end
            ST_START: begin
                if (at_end_i) begin
                    r_d.state = ST_DATA;
                    restart   = 1'b1;
                end
            end
            ST_DATA: begin
                if (r_q.shift[0] && at_half_i && !line_sync_i) begin
                    // Released for a 1 but someone holds the line low.
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.coll  = 1'b1;
                end else if (at_end_i) begin
                    restart   = 1'b1;
                    r_d.shift = r_q.shift >> 1;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.state = ST_STOP;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (at_end_i) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.ok    = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        // The enable is registered from the next state to keep the line glitch free.
        r_d.drive = (r_d.state == ST_START) ||
                    ((r_d.state == ST_DATA) && !r_d.shift[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, shift: '0, idx: '0,
                     drive: 1'b0, done: 1'b0, ok: 1'b0, coll: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign run_o       = (r_q.state != ST_IDLE);
    assign restart_o   = restart;
    assign drive_low_o = r_q.drive;
    assign busy_o      = (r_q.state != ST_IDLE);
    assign done_o      = r_q.done;
    assign ok_o        = r_q.ok;
    assign collide_o   = r_q.coll;

endmodule

// File: rtl/odl_byte_tx.sv
module odl_byte_tx #(
    parameter int BIT_CYCLES  = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_BITS-1:0] byte_i,
    input  logic                 line_i,
    output logic                 drive_low_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 ok_o,
    output logic                 collide_o
);

    logic line_sync;
    logic at_half;
    logic at_end;
    logic run;
    logic restart;

    odl_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .line_sync_o (line_sync)
    );

    odl_bit_timer #(
        .BIT_CYCLES (BIT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .at_half_o (at_half),
        .at_end_o  (at_end)
    );

    odl_tx_fsm #(
        .DATA_BITS (DATA_BITS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .byte_i      (byte_i),
        .line_sync_i (line_sync),
        .at_half_i   (at_half),
        .at_end_i    (at_end),
        .run_o       (run),
        .restart_o   (restart),
        .drive_low_o (drive_low_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ok_o        (ok_o),
        .collide_o   (collide_o)
    );

endmodule

// File: rtl/odl_byte_tx_chk.sv
module odl_byte_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic drive_low_o,
    input logic busy_o,
    input logic done_o,
    input logic ok_o,
    input logic collide_o
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !drive_low_o);                                        // R9

    AST_DONE_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ok_o ^ collide_o));                                   // R8

    AST_RESULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o || collide_o) |-> done_o);                                  // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                              // R4

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);                                        // R4

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> drive_low_o);                                   // R2

    AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> !$past(drive_low_o));                                    // R4

    AST_COLLIDE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        collide_o |-> (!drive_low_o && !$past(drive_low_o)));             // R5

endmodule

bind odl_byte_tx odl_byte_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drive_low_o (drive_low_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .collide_o   (collide_o)
);

// File: tb/odl_byte_tx_bench.sv
`timescale 1ns/1ps
module odl_byte_tx_bench;

    localparam int BC   = 16;
    localparam int HALF = BC / 2;
    localparam int NB   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       other_low = 1'b0;
    logic       line;
    logic       drive_low_o, busy_o, done_o, ok_o, collide_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int intf_lo = -1;
    int intf_hi = -1;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign line = ~(drive_low_o | other_low);

    odl_byte_tx #(.BIT_CYCLES(BC), .DATA_BITS(NB), .SYNC_STAGES(2)) u_odl_byte_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .byte_i      (byte_i),
        .line_i      (line),
        .drive_low_o (drive_low_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ok_o        (ok_o),
        .collide_o   (collide_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: frame position counter plus its own two-stage line copy.
    bit       m_busy = 0;
    int       m_cyc = 0;
    logic [7:0] m_byte = 8'h00;
    bit       e_done = 0, e_ok = 0, e_coll = 0;
    logic     ms1 = 1'b1, ms2 = 1'b1;

    always @(posedge clk) begin
        int pos;
        int ph;
        e_done = 0; e_ok = 0; e_coll = 0;
        if (!rst_n) begin
            m_busy = 0; m_cyc = 0; ms1 = 1'b1; ms2 = 1'b1;
        end else begin
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; m_cyc = 0; m_byte = byte_i;
                end
            end else begin
                pos = m_cyc / BC;
                ph  = m_cyc % BC;
                if (pos >= 1 && pos <= NB && m_byte[pos-1] && ph == HALF - 1 && !ms2) begin
                    m_busy = 0; e_done = 1; e_coll = 1;
                end else if (m_cyc == (NB + 2) * BC - 1) begin
                    m_busy = 0; e_done = 1; e_ok = 1;
                end else begin
                    m_cyc++;
                end
            end
            ms2 = ms1;
            ms1 = line;
        end
    end

    function automatic bit exp_drive();
        int pos;
        pos = m_cyc / BC;
        if (!m_busy) return 0;
        if (pos == 0) return 1;
        if (pos <= NB) return !m_byte[pos-1];
        return 0;
    endfunction

    // Interfering device and per-cycle comparison, both away from the active edge.
    always @(negedge clk) begin
        cyc++;
        other_low <= m_busy && (m_cyc >= intf_lo) && (m_cyc < intf_hi);
        if (rst_n) begin
            check("R3 drive_low_o per cycle", drive_low_o, exp_drive());
            check("R2 busy_o per cycle", busy_o, m_busy);
            check("R4 done_o per cycle", done_o, e_done);
            check("R4 ok_o per cycle", ok_o, e_ok);
            check("R5 collide_o per cycle", collide_o, e_coll);
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Sends one byte; coll_bit < 0 means a clean frame is expected.
    task automatic send(input logic [7:0] b, input int lo, input int hi,
                        input int coll_bit, input int spur_at, input string tag);
        int len;
        int exp_len;
        len = 0;
        @(negedge clk);
        intf_lo = lo; intf_hi = hi;
        byte_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 150000) begin
            if (busy_o) len++;
            start_i = (len == spur_at);
            if (len == spur_at) byte_i = ~b;
            @(negedge clk);
        end
        start_i = 1'b0;
        exp_len = (coll_bit < 0) ? (NB + 2) * BC : (1 + coll_bit) * BC + HALF;
        check({tag, " busy length"}, len, exp_len);
        check({tag, " ok"}, ok_o, (coll_bit < 0) ? 1 : 0);
        check({tag, " collide"}, collide_o, (coll_bit < 0) ? 0 : 1);
        intf_lo = -1; intf_hi = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 drive in reset", drive_low_o, 0);
        check("R1 busy in reset", busy_o, 0);
        check("R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 drive after reset", drive_low_o, 0);
        check("R1 busy after reset", busy_o, 0);
        check("R1 ok/collide after reset", ok_o | collide_o, 0);

        // R2 R3 R4: clean frames with distinct patterns
        send(8'hA5, -1, -1, -1, -1, "R3 A5");
        send(8'h00, -1, -1, -1, -1, "R3 00");
        send(8'hFF, -1, -1, -1, -1, "R4 FF");
        send(8'h01, -1, -1, -1, -1, "R3 01");
        send(8'h80, -1, -1, -1, -1, "R3 80");

        // R5: whole 1 bit held low -> collision
        send(8'hFF, 1 * BC, 2 * BC, 0, -1, "R5 bit0");
        send(8'hFF, 6 * BC, 7 * BC, 5, -1, "R5 bit5");
        send(8'h80, 8 * BC, 9 * BC, 7, -1, "R5 bit7");
        // R5 sample point: low from bit cycle HALF-3 collides, from HALF-2 does not
        send(8'hFF, 3 * BC + HALF - 3, 4 * BC, 2, -1, "R5 edge in");
        send(8'hFF, 3 * BC + HALF - 2, 4 * BC, -1, -1, "R6 late window");
        send(8'hFF, 3 * BC, 3 * BC + HALF - 3, -1, -1, "R6 early window");

        // R6: low during a 0 bit, the start bit and the stop bit has no effect
        send(8'h0F, 5 * BC, 6 * BC, -1, -1, "R6 zero bit");
        send(8'hFF, 0, BC, -1, -1, "R6 start bit");
        send(8'hFF, 9 * BC, 10 * BC, -1, -1, "R6 stop bit");

        // R7: start pulses during a frame are ignored
        send(8'h3C, -1, -1, -1, 5, "R7 spurious start");
        send(8'hC3, -1, -1, -1, 4 * BC + 3, "R7 mid-data start");

        // R8 R9: idle outputs stay quiet
        repeat (4) @(negedge clk);
        check("R9 idle drive", drive_low_o, 0);
        check("R8 idle done", done_o | ok_o | collide_o, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule